// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits beside one processor core. It holds at most one pending interrupt and drives the core's external interrupt line. The pending interrupt is either an external source offered by the source layer or the processor's own inter-processor interrupt (IPI). The core works it through one-cycle register commands:

- accept the pending word;
- poll the pending word without side effects;
- set the current processor priority;
- set the IPI priority;
- write end-of-interrupt.

Priorities are 8 bits, and a numerically lower value is more favoured. The value 0xFF means masked or idle. The pending word packs the current processor priority in bits 31:24 and the pending source number in bits 23:0. A source number of zero means nothing is pending. The IPI always uses the reserved source number 2.

The source layer offers requests as a source number with a priority. Priority comparison can refuse a new request, or a new request can displace the pending one. Every external source that is refused, displaced or cleared gets a reject pulse back, so that the source layer can offer it again later. The block also sends an end-of-interrupt pulse carrying the source number that the core wrote. It sends a resend pulse when the core has made room to take new work.

Top module: `intr_presenter`

## Requirements
- R1: After reset the pending word is 0x00000000, the pending priority and the IPI priority are both 0xFF, the interrupt line is low and no pulse output is active. Whenever no source is pending, the pending priority is 0xFF.
- R2: A request whose priority is greater than or equal to the current processor priority is refused. Refusal gives a reject pulse carrying that request's source number and leaves the pending state unchanged.
- R3: A request is also refused, with a reject of its own source number, when a source is already pending whose priority is less than or equal to the request's priority.
- R4: A request that is not refused loads its source number and priority and raises the interrupt line. If the displaced pending source was external, it is rejected; a request with source number 0 is ignored. The interrupt line is high exactly when the pending source field is non-zero.
- R5: Command 0 (accept) returns the full pending word and lowers the line. The old pending priority moves into bits 31:24, the source field is cleared and the pending priority becomes 0xFF.
- R6: Command 1 (poll) returns the pending word and changes no state.
- R7: Command 2 sets the current priority from write bits 7:0. If the new value is more favoured than the old value, a pending source whose priority is not strictly more favoured than the new value is cleared, the line drops and the source is rejected if it is external.
- R8: Command 2 with a value equal to or less favoured than the old one, while nothing is pending, issues a resend pulse.
- R9: Command 3 sets the IPI priority from write bits 7:0. If that value is more favoured than the current priority, the IPI (source 2, at the IPI priority) takes over, unless the pending source's priority is less than or equal to the IPI priority. An external source that the IPI displaces is rejected.
- R10: An IPI that is displaced or cleared never produces a reject pulse.
- R11: Command 4 (end-of-interrupt) copies write bits 31:24 into the current priority and pulses end-of-interrupt with write bits 23:0. If nothing is pending, it also issues a resend pulse.
- R12: Every resend first rechecks the IPI when the IPI priority is more favoured than the newly set current priority, so that the IPI can be presented in the same cycle.
- R13: Each command or request takes effect at the next clock edge, and its outputs appear in the following cycle. Read data is valid for one cycle. Reject, end-of-interrupt and resend are single-cycle pulses. Command codes 5 to 7 are ignored. Commands and requests are not presented in the same cycle; if they are, the command takes effect and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Register command strobe |
| cmd_op | input | 3 | Command code: 0 accept, 1 poll, 2 current priority, 3 IPI priority, 4 end-of-interrupt |
| cmd_wdata | input | 32 | Command write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 32 | Pending word returned by accept or poll |
| req_valid | input | 1 | Source layer presents a request |
| req_src | input | 24 | Requested source number |
| req_prio | input | 8 | Requested priority |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_src | output | 24 | Source number for end-of-interrupt |
| resend_req | output | 1 | Resend pulse to the source layer |
| irq_out | output | 1 | Interrupt line to the core |

## Verification
A directed sequence drives requests at priorities below, equal to and above the current priority and the pending priority. It separates the refusal rules from the displacement rule and shows which source the reject pulse names. IPI priority writes are tried both just above and just below the pending priority, and once with an IPI pending that a later request or priority write displaces. This shows that an IPI yields no reject while an external source does. Priority writes and end-of-interrupt are tried with and without a pending source, to tell a resend that presents the IPI apart from a plain resend. A long random mix of commands and requests then follows, compared every cycle against a behavioural model.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
    localparam int PRIO_W_DEF = 8;
    localparam int SRC_W_DEF  = 24;
    localparam int OP_W       = 3;
    localparam int N_OPS      = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ACCEPT = 3'd0,
        OP_POLL   = 3'd1,
        OP_CPPR   = 3'd2,
        OP_IPI    = 3'd3,
        OP_EOI    = 3'd4
    } ipres_op_e;
endpackage

// File: rtl/ipres_cmd_decode.sv
module ipres_cmd_decode #(
    parameter int OP_W  = ipres_pkg::OP_W,
    parameter int N_OPS = ipres_pkg::N_OPS
) (
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    output logic [N_OPS-1:0] op_hit
);
    // one strobe per defined code; unknown codes hit nothing
    for (genvar i = 0; i < N_OPS; i++) begin : g_hit
        assign op_hit[i] = cmd_valid && (cmd_op == OP_W'(i));
    end
endmodule

// File: rtl/ipres_req_eval.sv
module ipres_req_eval #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic              req_valid,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic [PRIO_W-1:0] cur_cppr,
    input  logic [SRC_W-1:0]  cur_src,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_ext,
    output logic              take,
    output logic              refuse,
    output logic              displace
);
    logic live;
    logic busy;
    logic blocked;

    assign live     = req_valid && (req_src != '0);
    assign busy     = (cur_src != '0);
    // refused by the core's priority or by an equal-or-better pending source
    assign blocked  = (req_prio >= cur_cppr) || (busy && (pend_prio <= req_prio));
    assign refuse   = live && blocked;
    assign take     = live && !blocked;
    assign displace = take && busy && pend_ext;
endmodule

// File: rtl/ipres_ipi_check.sv
module ipres_ipi_check #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic              enable,
    input  logic [PRIO_W-1:0] ipi_prio,
    input  logic [PRIO_W-1:0] cppr_eff,
    input  logic [SRC_W-1:0]  cur_src,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_ext,
    output logic              take,
    output logic              displace
);
    logic fire;
    logic hold;

    assign fire     = enable && (ipi_prio < cppr_eff);
    assign hold     = (cur_src != '0) && (pend_prio <= ipi_prio);
    assign take     = fire && !hold;
    assign displace = take && (cur_src != '0) && pend_ext;
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter #(
    parameter int PRIO_W  = ipres_pkg::PRIO_W_DEF,
    parameter int SRC_W   = ipres_pkg::SRC_W_DEF,
    parameter int IPI_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [ipres_pkg::OP_W-1:0] cmd_op,
    input  logic [PRIO_W+SRC_W-1:0] cmd_wdata,
    output logic                    rd_valid,
    output logic [PRIO_W+SRC_W-1:0] rd_data,
    input  logic                    req_valid,
    input  logic [SRC_W-1:0]        req_src,
    input  logic [PRIO_W-1:0]       req_prio,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src,
    output logic                    resend_req,
    output logic                    irq_out
);
    import ipres_pkg::*;

    localparam int WORD_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pp;
        logic [PRIO_W-1:0] mfrr;
        logic              ext;
        logic              irq;
        logic              rej_v;
        logic [SRC_W-1:0]  rej_src;
        logic              eoi_v;
        logic [SRC_W-1:0]  eoi_src;
        logic              resend;
        logic              rd_v;
        logic [WORD_W-1:0] rd;
    } pres_state_t;

    pres_state_t st_d, st_q;

    // state views shared with the bound checker
    logic [PRIO_W-1:0] cur_cppr;
    logic [SRC_W-1:0]  cur_src;
    logic [PRIO_W-1:0] cur_pp;
    logic [WORD_W-1:0] cur_word;

    assign cur_cppr = st_q.cppr;
    assign cur_src  = st_q.src;
    assign cur_pp   = st_q.pp;
    assign cur_word = {st_q.cppr, st_q.src};

    // command decode
    logic [N_OPS-1:0] op_hit;
    logic do_accept, do_poll, do_cppr, do_ipi, do_eoi;

    ipres_cmd_decode #(
        .OP_W  (OP_W),
        .N_OPS (N_OPS)
    ) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .op_hit    (op_hit)
    );

    assign do_accept = op_hit[OP_ACCEPT];
    assign do_poll   = op_hit[OP_POLL];
    assign do_cppr   = op_hit[OP_CPPR];
    assign do_ipi    = op_hit[OP_IPI];
    assign do_eoi    = op_hit[OP_EOI];

    // write-data fields
    logic [PRIO_W-1:0] wr_prio;
    logic [PRIO_W-1:0] eoi_prio;
    logic [SRC_W-1:0]  eoi_num;
    logic              prio_raise;
    logic              nothing_pending;

    assign wr_prio         = cmd_wdata[PRIO_W-1:0];
    assign eoi_prio        = cmd_wdata[WORD_W-1:SRC_W];
    assign eoi_num         = cmd_wdata[SRC_W-1:0];
    assign prio_raise      = wr_prio < st_q.cppr;
    assign nothing_pending = (st_q.src == '0);

    // resend happens on a lowered priority or an end-of-interrupt with an empty slot
    logic resend_go;
    assign resend_go = nothing_pending && ((do_cppr && !prio_raise) || do_eoi);

    // IPI check runs against the priorities as they stand after the command
    logic              ipi_en;
    logic [PRIO_W-1:0] ipi_prio_eff;
    logic [PRIO_W-1:0] ipi_cppr_eff;
    logic              ipi_take;
    logic              ipi_disp;

    assign ipi_en       = do_ipi || resend_go;
    assign ipi_prio_eff = do_ipi ? wr_prio : st_q.mfrr;
    assign ipi_cppr_eff = do_ipi ? st_q.cppr : (do_cppr ? wr_prio : eoi_prio);

    ipres_ipi_check #(
        .PRIO_W (PRIO_W),
        .SRC_W  (SRC_W)
    ) u_ipi (
        .enable    (ipi_en),
        .ipi_prio  (ipi_prio_eff),
        .cppr_eff  (ipi_cppr_eff),
        .cur_src   (st_q.src),
        .pend_prio (st_q.pp),
        .pend_ext  (st_q.ext),
        .take      (ipi_take),
        .displace  (ipi_disp)
    );

    // source-side request evaluation, only in cycles without a command
    logic req_take;
    logic req_refuse;
    logic req_disp;

    ipres_req_eval #(
        .PRIO_W (PRIO_W),
        .SRC_W  (SRC_W)
    ) u_req (
        .req_valid (req_valid && !cmd_valid),
        .req_src   (req_src),
        .req_prio  (req_prio),
        .cur_cppr  (st_q.cppr),
        .cur_src   (st_q.src),
        .pend_prio (st_q.pp),
        .pend_ext  (st_q.ext),
        .take      (req_take),
        .refuse    (req_refuse),
        .displace  (req_disp)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rej_v   = 1'b0;
        st_d.eoi_v   = 1'b0;
        st_d.resend  = 1'b0;
        st_d.rd_v    = 1'b0;

        if (do_accept) begin
            st_d.rd_v = 1'b1;
            st_d.rd   = cur_word;
            st_d.cppr = st_q.pp;
            st_d.src  = '0;
            st_d.pp   = PRIO_IDLE;
            st_d.ext  = 1'b0;
            st_d.irq  = 1'b0;
        end

        if (do_poll) begin
            st_d.rd_v = 1'b1;
            st_d.rd   = cur_word;
        end

        if (do_cppr) begin
            st_d.cppr = wr_prio;
            if (prio_raise && !nothing_pending && (wr_prio <= st_q.pp)) begin
                st_d.src = '0;
                st_d.pp  = PRIO_IDLE;
                st_d.irq = 1'b0;
                st_d.ext = 1'b0;
                if (st_q.ext) begin
                    st_d.rej_v   = 1'b1;
                    st_d.rej_src = st_q.src;
                end
            end
        end

        if (do_ipi) begin
            st_d.mfrr = wr_prio;
        end

        if (do_eoi) begin
            st_d.cppr    = eoi_prio;
            st_d.eoi_v   = 1'b1;
            st_d.eoi_src = eoi_num;
        end

        if (resend_go) begin
            st_d.resend = 1'b1;
        end

        if (ipi_take) begin
            if (ipi_disp) begin
                st_d.rej_v   = 1'b1;
                st_d.rej_src = st_q.src;
            end
            st_d.src = IPI_NUM;
            st_d.pp  = ipi_prio_eff;
            st_d.ext = 1'b0;
            st_d.irq = 1'b1;
        end

        if (req_refuse) begin
            st_d.rej_v   = 1'b1;
            st_d.rej_src = req_src;
        end

        if (req_take) begin
            if (req_disp) begin
                st_d.rej_v   = 1'b1;
                st_d.rej_src = st_q.src;
            end
            st_d.src = req_src;
            st_d.pp  = req_prio;
            st_d.ext = 1'b1;
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pp   <= PRIO_IDLE;
            st_q.mfrr <= PRIO_IDLE;
        end else begin
            st_q      <= st_d;
        end
    end

    assign rd_valid   = st_q.rd_v;
    assign rd_data    = st_q.rd;
    assign rej_valid  = st_q.rej_v;
    assign rej_src    = st_q.rej_src;
    assign eoi_valid  = st_q.eoi_v;
    assign eoi_src    = st_q.eoi_src;
    assign resend_req = st_q.resend;
    assign irq_out    = st_q.irq;
endmodule

// File: rtl/ipres_checker.sv
module ipres_checker #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [2:0]              cmd_op,
    input logic [PRIO_W+SRC_W-1:0] cmd_wdata,
    input logic                    req_valid,
    input logic [SRC_W-1:0]        req_src,
    input logic [PRIO_W-1:0]       req_prio,
    input logic                    irq_out,
    input logic                    rej_valid,
    input logic [SRC_W-1:0]        rej_src,
    input logic                    eoi_valid,
    input logic [SRC_W-1:0]        eoi_src,
    input logic                    rd_valid,
    input logic [PRIO_W+SRC_W-1:0] rd_data,
    input logic [PRIO_W-1:0]       cur_cppr,
    input logic [SRC_W-1:0]        cur_src,
    input logic [PRIO_W-1:0]       cur_pp
);
    localparam int WORD_W = PRIO_W + SRC_W;

    a_r1_idle_prio_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src == '0) |-> (cur_pp == '1));

    a_r2_refuse_low_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cmd_valid && (req_src != '0) && (req_prio >= cur_cppr))
        |=> (rej_valid && (rej_src == $past(req_src))));

    a_r4_line_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (cur_src != '0));

    a_r5_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd0))
        |=> (!irq_out && (cur_src == '0) && rd_valid
             && (rd_data == $past({cur_cppr, cur_src}))));

    a_r6_poll_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd1))
        |=> (rd_valid && (rd_data == $past({cur_cppr, cur_src}))
             && $stable(cur_src) && $stable(cur_cppr)));

    a_r11_eoi_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd4))
        |=> (eoi_valid && (eoi_src == $past(cmd_wdata[SRC_W-1:0]))
             && (cur_cppr == $past(cmd_wdata[WORD_W-1:SRC_W]))));
endmodule

bind intr_presenter ipres_checker #(
    .PRIO_W (PRIO_W),
    .SRC_W  (SRC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .req_valid (req_valid),
    .req_src   (req_src),
    .req_prio  (req_prio),
    .irq_out   (irq_out),
    .rej_valid (rej_valid),
    .rej_src   (rej_src),
    .eoi_valid (eoi_valid),
    .eoi_src   (eoi_src),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .cur_cppr  (cur_cppr),
    .cur_src   (cur_src),
    .cur_pp    (cur_pp)
);

// File: tb/intr_presenter_tb.sv
module intr_presenter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K_IDLE = -1;
    localparam int K_REQ  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;
    logic        irq_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_presenter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_wdata  (cmd_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .req_valid  (req_valid),
        .req_src    (req_src),
        .req_prio   (req_prio),
        .rej_valid  (rej_valid),
        .rej_src    (rej_src),
        .eoi_valid  (eoi_valid),
        .eoi_src    (eoi_src),
        .resend_req (resend_req),
        .irq_out    (irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference model
    int m_cppr = 0, m_src = 0, m_pp = 255, m_ipi = 255;
    bit m_ext = 0, m_irq = 0;
    bit e_rej = 0, e_eoi = 0, e_resend = 0, e_rd = 0;
    int e_rej_src = 0, e_eoi_src = 0;
    logic [31:0] e_rd_data = '0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic m_reject(input int s);
        e_rej = 1;
        e_rej_src = s;
    endtask

    task automatic m_ipi_check();
        if (m_src != 0 && m_pp <= m_ipi) return;
        if (m_src != 0 && m_ext) m_reject(m_src);
        m_src = 2;
        m_pp  = m_ipi;
        m_ext = 0;
        m_irq = 1;
    endtask

    task automatic m_resend();
        if (m_ipi < m_cppr) m_ipi_check();
        e_resend = 1;
    endtask

    task automatic compare(input string tag);
        chk(tag, "irq_out", 32'(irq_out), 32'(m_irq));
        chk(tag, "rej_valid", 32'(rej_valid), 32'(e_rej));
        if (e_rej) chk(tag, "rej_src", 32'(rej_src), 32'(e_rej_src));
        chk(tag, "eoi_valid", 32'(eoi_valid), 32'(e_eoi));
        if (e_eoi) chk(tag, "eoi_src", 32'(eoi_src), 32'(e_eoi_src));
        chk(tag, "resend_req", 32'(resend_req), 32'(e_resend));
        chk(tag, "rd_valid", 32'(rd_valid), 32'(e_rd));
        if (e_rd) chk(tag, "rd_data", rd_data, e_rd_data);
    endtask

    // kind: K_IDLE, K_REQ (a=src, b=prio) or a command code (a=write data)
    task automatic step(input string tag, input int kind, input int a, input int b);
        @(negedge clk);
        compare(tag);
        e_rej = 0; e_eoi = 0; e_resend = 0; e_rd = 0;
        cmd_valid = 1'b0; req_valid = 1'b0;
        if (kind == K_REQ) begin
            req_valid = 1'b1; req_src = 24'(a); req_prio = 8'(b);
            if (a != 0) begin
                if (b >= m_cppr || (m_src != 0 && m_pp <= b)) begin
                    m_reject(a);
                end else begin
                    if (m_src != 0 && m_ext) m_reject(m_src);
                    m_src = a; m_pp = b; m_ext = 1; m_irq = 1;
                end
            end
        end else if (kind >= 0) begin
            cmd_valid = 1'b1; cmd_op = 3'(kind); cmd_wdata = 32'(a);
            case (kind)
                0: begin
                    e_rd = 1; e_rd_data = {8'(m_cppr), 24'(m_src)};
                    m_cppr = m_pp; m_src = 0; m_pp = 255; m_ext = 0; m_irq = 0;
                end
                1: begin
                    e_rd = 1; e_rd_data = {8'(m_cppr), 24'(m_src)};
                end
                2: begin
                    int v = a & 255;
                    int old = m_cppr;
                    m_cppr = v;
                    if (v < old) begin
                        if (m_src != 0 && v <= m_pp) begin
                            if (m_ext) m_reject(m_src);
                            m_src = 0; m_pp = 255; m_ext = 0; m_irq = 0;
                        end
                    end else if (m_src == 0) begin
                        m_resend();
                    end
                end
                3: begin
                    m_ipi = a & 255;
                    if (m_ipi < m_cppr) m_ipi_check();
                end
                4: begin
                    m_cppr = (a >> 24) & 255;
                    e_eoi = 1; e_eoi_src = a & 32'h00FF_FFFF;
                    if (m_src == 0) m_resend();
                end
                default: ;
            endcase
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL R13 watchdog actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 reset", 1, 0, 0);
        step("R1 reset poll", 0, 0, 0);          // word 0, cppr takes 0xFF
        step("R1 accept idle", 1, 0, 0);         // expect FF000000
        step("R4 load", K_REQ, 'h100, 5);
        step("R6 poll", 1, 0, 0);
        step("R6 poll again", 1, 0, 0);
        step("R3 equal pending", K_REQ, 'h200, 5);
        step("R4 displace", K_REQ, 'h300, 3);
        step("R5 accept", 0, 0, 0);
        step("R2 equal cppr", K_REQ, 'h400, 3);
        step("R2 above cppr", K_REQ, 'h401, 7);
        step("R4 zero source", K_REQ, 0, 0);
        step("R11 eoi empty", 4, 'hFF000300, 0);
        step("R4 load ext", K_REQ, 'h500, 6);
        step("R9 ipi held", 3, 'h08, 0);
        step("R9 ipi takes", 3, 'h04, 0);
        step("R9 poll", 1, 0, 0);
        step("R10 ipi displaced", K_REQ, 'h600, 2);
        step("R7 clear ext", 2, 'h02, 0);
        step("R7 poll", 1, 0, 0);
        step("R7 raise empty", 2, 'h01, 0);
        step("R8 lower resend", 2, 'h10, 0);      // IPI at 4 re-presented
        step("R12 poll", 1, 0, 0);
        step("R10 clear ipi", 2, 'h03, 0);
        step("R5 accept empty", 0, 0, 0);
        step("R9 mask ipi", 3, 'hFF, 0);
        step("R4 load", K_REQ, 'h700, 9);
        step("R5 accept ext", 0, 0, 0);
        step("R9 ipi empty", 3, 'h05, 0);
        step("R5 accept ipi", 0, 0, 0);
        step("R12 eoi resend ipi", 4, 'h09000002, 0);
        step("R10 ipi displaced", K_REQ, 'h800, 1);
        step("R11 eoi busy", 4, 'hFF000123, 0);
        step("R7 keep better", 2, 'h05, 0);
        step("R7 poll", 1, 0, 0);
        step("R13 bad op", 6, 'h00000000, 0);
        step("R13 poll", 1, 0, 0);
        step("R13 idle", K_IDLE, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 6);
            int p = ($urandom_range(0, 7) == 0) ? 255 : $urandom_range(0, 15);
            if (k == 5) step("R13 mix", K_REQ, $urandom_range(0, 40), p);
            else if (k == 6) step("R13 mix", K_IDLE, 0, 0);
            else if (k == 4) step("R11 mix", 4, (p << 24) | $urandom_range(0, 40), 0);
            else step("R13 mix", k, p, 0);
        end
        step("R13 final", K_IDLE, 0, 0);
        step("R13 final", K_IDLE, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule